// File: doc/BRIEF.md
# Parallel-Bus to Serial PSRAM Bridge

This block sits between an 8-bit parallel CPU bus and a serial pseudo-static RAM. The serial RAM stands in for a RAM disk. Software loads a track number and a sector number into two registers. It then writes a control register to open a burst in the read or write direction. The bridge combines track and sector into a 24-bit byte address with the byte offset at zero. It lowers chip select and sends a one-byte opcode followed by the three address bytes, most significant byte first.

Once the burst is open, every access to the data register moves exactly one byte over SPI. No extra "go" write is needed. In a read burst the bridge always holds the next byte in a buffer. A data read therefore returns at once and starts fetching the byte after it. A busy bit in the status register tells software when the next access may be made.

The serial memory accepts only a limited number of bytes after one address phase. When the burst counter reaches that limit, the bridge closes the frame on its own and reopens it at the current address.

The sequencer moves through five named states:
- IDLE: chip select is high and no burst is open.
- GAP: chip select is held high for one cycle before a header.
- HEADER: the opcode and the three address bytes are shifted out.
- READY: the burst is open and the bridge waits for a data access.
- BYTE: one data byte is shifted.

Transitions:
- IDLE to GAP: on a control write.
- GAP to HEADER: always, after one cycle.
- HEADER to BYTE: when a prefetch is pending after the last address byte.
- HEADER to READY: when no prefetch is pending after the last address byte.
- READY to GAP: on a control write, or on a data access when the burst limit has been reached.
- READY to IDLE: on a track or sector write.
- READY to BYTE: on an accepted data access.
- BYTE to READY: when the shift completes.

Top module: `psram_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and the status register (register 3, read) reads 0x00.
- R2: The burst start address is track shifted left by 15 plus sector shifted left by 7. The track is written to register 0 and the sector to register 1. After the opcode the address is sent as three bytes, most significant byte first.
- R3: SPI mode 0 is used. SCLK is low whenever chip select is high. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge. Bits go most significant bit first.
- R4: A write to register 3 opens a burst, and chip select stays low for the whole frame. Bit 0 of the written value selects the direction: 1 sends opcode 0x03 (read), 0 sends opcode 0x02 (write).
- R5: In a write burst, each write to register 2 sends exactly one byte, to consecutive addresses within the same frame.
- R6: Opening a read burst fetches the first byte at once. Each read of register 2 returns the buffered byte in the same cycle and starts fetching the next byte.
- R7: Status bit 0 (busy) is 1 while a gap, header or data shift is in progress. Bit 1 is 1 while a burst is open. Bit 2 is 1 when the open burst is a read burst. SCLK toggles only while busy is 1.
- R8: Any bus access made while busy is 1 is ignored. A data write in a read burst is ignored. A data read in a write burst is ignored.
- R9: No frame carries more than 1024 data bytes. A data access beyond that limit raises chip select and sends a new header at the next address. The transfer then continues.
- R10: A track or sector write that is accepted while a burst is open closes the burst: chip select is high from the next cycle on.
- R11: A control write during an open burst raises chip select on the next cycle. It then reopens the burst at the base address, in the newly chosen direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_reg | input | 2 | Register select: 0 track, 1 sector, 2 data, 3 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from registers) |
| spi_cs_n | output | 1 | Serial RAM chip select, active low |
| spi_sclk | output | 1 | Serial clock, half the system clock rate |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
The bound checker watches the SPI pins on every cycle. It checks that SCLK stays low outside a frame, that MOSI is stable at each rising edge, and that SCLK toggles only while busy is reported. It also checks that an accepted track, sector or control write raises chip select on the next cycle, and it counts clock edges to keep each frame within the burst limit.

Only the bench scenarios, run against a behavioural serial memory, can show the rest. That covers opcode and address content, data round trips, prefetch order, dropped accesses, and the reopened frame that continues at the right address after 1024 bytes.

// File: rtl/psb_pkg.sv
package psb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_HEADER,
        ST_READY,
        ST_BYTE
    } psb_state_t;

    localparam logic [1:0] REG_TRACK  = 2'd0;
    localparam logic [1:0] REG_SECTOR = 2'd1;
    localparam logic [1:0] REG_DATA   = 2'd2;
    localparam logic [1:0] REG_CTRL   = 2'd3;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/psb_shifter.sv
// One-byte SPI mode 0 master shifter; SCLK runs at clk/2.
module psb_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_tx, sh_rx;
    logic [BC_W-1:0]   bcnt;
    logic              phase, active, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_tx  <= '0;
            sh_rx  <= '0;
            bcnt   <= '0;
            phase  <= 1'b0;
            active <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    phase  <= 1'b0;
                    sh_tx  <= tx;
                    bcnt   <= '0;
                end
            end else if (!phase) begin
                // this edge raises SCLK: capture the bit the memory set up
                phase <= 1'b1;
                sh_rx <= {sh_rx[BYTE_W-2:0], miso};
            end else begin
                // this edge lowers SCLK: present the next bit
                phase <= 1'b0;
                sh_tx <= {sh_tx[BYTE_W-2:0], 1'b0};
                bcnt  <= bcnt + 1'b1;
                if (bcnt == BC_W'(BYTE_W - 1)) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign sclk = active & phase;
    assign mosi = sh_tx[BYTE_W-1];
    assign busy = active;
    assign done = done_q;
    assign rx   = sh_rx;
endmodule

// File: rtl/psb_seq.sv
// Burst sequencer: header framing, data bytes, prefetch and burst cap.
module psb_seq
    import psb_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BURST_MAX = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_req,
    input  logic              open_rd,
    input  logic              close_req,
    input  logic              xfer_req,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [7:0]        wr_byte,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    output logic              cs_n,
    output logic              busy,
    output logic              burst_open,
    output logic              burst_rd,
    output logic [7:0]        rd_buf
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
    localparam int CNT_W      = $clog2(BURST_MAX + 1);

    psb_state_t        state, nxt;
    logic [IDX_W-1:0]  idx;
    logic              launched, pend, dir_rd;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        txbuf, rbuf, hdr_byte;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (open_req) nxt = ST_GAP;
            ST_GAP:    nxt = ST_HEADER;
            ST_HEADER: if (sh_done && idx == IDX_W'(ADDR_BYTES))
                           nxt = pend ? ST_BYTE : ST_READY;
            ST_READY: begin
                if (open_req)       nxt = ST_GAP;
                else if (close_req) nxt = ST_IDLE;
                else if (xfer_req)  nxt = (cnt == CNT_W'(BURST_MAX)) ? ST_GAP : ST_BYTE;
            end
            ST_BYTE:   if (sh_done) nxt = ST_READY;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            launched <= 1'b0;
            pend     <= 1'b0;
            dir_rd   <= 1'b0;
            ptr      <= '0;
            cnt      <= '0;
            txbuf    <= '0;
            rbuf     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (open_req) begin
                    dir_rd <= open_rd;
                    ptr    <= base_addr;
                    pend   <= open_rd;
                end
                ST_GAP: begin
                    idx      <= '0;
                    launched <= 1'b0;
                    cnt      <= '0;
                end
                ST_HEADER: begin
                    if (!launched) launched <= 1'b1;
                    if (sh_done) begin
                        launched <= 1'b0;
                        idx      <= idx + 1'b1;
                    end
                end
                ST_READY: begin
                    if (open_req) begin
                        dir_rd <= open_rd;
                        ptr    <= base_addr;
                        pend   <= open_rd;
                    end else if (xfer_req) begin
                        pend     <= 1'b1;
                        txbuf    <= wr_byte;
                        launched <= 1'b0;
                    end
                end
                ST_BYTE: begin
                    if (!launched) launched <= 1'b1;
                    if (sh_done) begin
                        launched <= 1'b0;
                        pend     <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        cnt      <= cnt + 1'b1;
                        if (dir_rd) rbuf <= sh_rx;
                    end
                end
                default: ;
            endcase
        end
    end

    // header byte: opcode first, then address bytes MSB first
    always_comb begin
        if (idx == '0) hdr_byte = dir_rd ? OP_READ : OP_WRITE;
        else           hdr_byte = 8'(ptr >> (8 * (ADDR_BYTES - int'(idx))));
    end

    // outputs
    always_comb begin
        cs_n       = (state == ST_IDLE) || (state == ST_GAP);
        busy       = (state == ST_GAP) || (state == ST_HEADER) || (state == ST_BYTE);
        burst_open = (state != ST_IDLE);
        burst_rd   = burst_open && dir_rd;
        sh_start   = ((state == ST_HEADER) || (state == ST_BYTE)) && !launched;
        sh_tx      = (state == ST_BYTE) ? (dir_rd ? 8'h00 : txbuf) : hdr_byte;
        rd_buf     = rbuf;
    end
endmodule

// File: rtl/psram_bridge.sv
module psram_bridge
    import psb_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int TRK_W     = 8,
    parameter int SEC_W     = 8,
    parameter int OFS_W     = 7,
    parameter int BURST_MAX = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic [1:0] bus_reg,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int SEC_SHIFT = OFS_W;
    localparam int TRK_SHIFT = OFS_W + SEC_W;

    logic [TRK_W-1:0]  trk;
    logic [SEC_W-1:0]  sec;
    logic [ADDR_W-1:0] base_addr;
    logic              busy, burst_open, burst_rd;
    logic              acc_ok, open_req, close_req, xfer_req;
    logic              sh_start, sh_done;
    logic [7:0]        sh_tx, sh_rx, rd_buf;

    assign acc_ok    = bus_en && !busy;
    assign open_req  = acc_ok && bus_we && (bus_reg == REG_CTRL);
    assign close_req = acc_ok && bus_we && ((bus_reg == REG_TRACK) || (bus_reg == REG_SECTOR));
    assign xfer_req  = acc_ok && burst_open && (bus_reg == REG_DATA) && (bus_we != burst_rd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk <= '0;
            sec <= '0;
        end else if (close_req) begin
            if (bus_reg == REG_TRACK) trk <= bus_wdata[TRK_W-1:0];
            else                      sec <= bus_wdata[SEC_W-1:0];
        end
    end

    assign base_addr = (ADDR_W'(trk) << TRK_SHIFT) | (ADDR_W'(sec) << SEC_SHIFT);

    always_comb begin
        unique case (bus_reg)
            REG_DATA: bus_rdata = rd_buf;
            REG_CTRL: bus_rdata = {5'b0, burst_rd, burst_open, busy};
            default:  bus_rdata = 8'h00;
        endcase
    end

    psb_seq #(
        .ADDR_W    (ADDR_W),
        .BURST_MAX (BURST_MAX)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_req   (open_req),
        .open_rd    (bus_wdata[0]),
        .close_req  (close_req),
        .xfer_req   (xfer_req),
        .base_addr  (base_addr),
        .wr_byte    (bus_wdata),
        .sh_done    (sh_done),
        .sh_rx      (sh_rx),
        .sh_start   (sh_start),
        .sh_tx      (sh_tx),
        .cs_n       (spi_cs_n),
        .busy       (busy),
        .burst_open (burst_open),
        .burst_rd   (burst_rd),
        .rd_buf     (rd_buf)
    );

    logic sh_busy;

    psb_shifter #(.BYTE_W(8)) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx)
    );
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
    parameter int ADDR_W    = 24,
    parameter int BURST_MAX = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       busy,
    input logic       bus_en,
    input logic       bus_we,
    input logic [1:0] bus_reg
);
    localparam int EDGE_LIMIT = (ADDR_W / 8 + 1 + BURST_MAX) * 8;

    logic sclk_q;
    int   edges;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            edges  <= 0;
        end else begin
            sclk_q <= sclk;
            if (cs_n)                edges <= 0;
            else if (sclk && !sclk_q) edges <= edges + 1;
        end
    end

    // R3: clock parked low outside a frame
    a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R3: data line is set up before the rising edge and held through it
    a_r3_mosi_setup: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R7: serial clock only runs while busy is reported
    a_r7_busy_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

    // R9: a frame never exceeds header plus the burst cap
    a_r9_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
        edges <= EDGE_LIMIT);

    // R10: accepted track/sector write leaves chip select high
    a_r10_close_drops_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !busy && (bus_reg == 2'd0 || bus_reg == 2'd1)) |=> cs_n);

    // R11: accepted control write raises chip select before the new header
    a_r11_reopen_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !busy && bus_reg == 2'd3) |=> cs_n);
endmodule

bind psram_bridge psb_checker #(
    .ADDR_W    (ADDR_W),
    .BURST_MAX (BURST_MAX)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .busy    (busy),
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_reg (bus_reg)
);

// File: tb/test_psram_bridge.sv
`timescale 1ns/1ps
module test_psram_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_reg = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    psram_bridge i_psram_bridge (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- behavioural serial memory ----------------
    bit [7:0]  mem   [4096];
    bit        wflag [4096];
    int        m_bit = 0, m_byte = 0, m_frames = 0;
    int        m_last_fbytes = 0, m_max_fbytes = 0;
    logic [7:0]  m_sr = 8'h00, m_cmd = 8'h00, m_out = 8'h00;
    logic [23:0] m_addr = 24'h0, m_ptr = 24'h0;

    function automatic logic [7:0] pat(input logic [23:0] a);
        return 8'(a[7:0] * 3) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_rd(input logic [23:0] a);
        return wflag[a[11:0]] ? mem[a[11:0]] : pat(a);
    endfunction

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            m_last_fbytes = (m_byte > 4) ? m_byte - 4 : 0;
            if (m_last_fbytes > m_max_fbytes) m_max_fbytes = m_last_fbytes;
            m_bit  = 0;
            m_byte = 0;
        end else begin
            m_sr = {m_sr[6:0], spi_mosi};
            m_bit++;
            if (m_bit == 8) begin
                m_bit = 0;
                if (m_byte == 0) m_cmd = m_sr;
                else if (m_byte <= 3) m_addr = {m_addr[15:0], m_sr};
                if (m_byte == 3) begin
                    m_ptr = m_addr;
                    m_frames++;
                    if (m_cmd == 8'h03) begin m_out = mem_rd(m_ptr); m_ptr++; end
                end else if (m_byte >= 4) begin
                    if (m_cmd == 8'h02) begin
                        mem[m_ptr[11:0]]   = m_sr;
                        wflag[m_ptr[11:0]] = 1'b1;
                        m_ptr++;
                    end else begin
                        m_out = mem_rd(m_ptr);
                        m_ptr++;
                    end
                end
                m_byte++;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && m_byte >= 4 && m_cmd == 8'h03) spi_miso = m_out[7 - m_bit];
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] r, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_reg = r;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int n = 0;
        do begin
            bus_rd(2'd3, s);
            n++;
        end while (s[0] && n < 200);
        if (s[0]) check(1'b0, "R7 busy never cleared", 1, 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R7 watchdog act=hung exp=done");
        summary();
    end

    // track, sector, expected 24-bit start address
    localparam logic [39:0] VEC [6] = '{
        {8'h00, 8'h00, 24'h000000},
        {8'h01, 8'h00, 24'h008000},
        {8'h00, 8'h01, 24'h000080},
        {8'hFF, 8'hFF, 24'h7FFF80},
        {8'h12, 8'h34, 24'h091A00},
        {8'hA5, 8'h5A, 24'h52AD00}
    };

    initial begin
        logic [7:0] d;
        int f0;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n === 1'b1, "R1 cs_n after reset", int'(spi_cs_n), 1);
        check(spi_sclk === 1'b0, "R1 sclk after reset", int'(spi_sclk), 0);
        bus_rd(2'd3, d);
        check(d === 8'h00, "R1 status after reset", d, 0);

        // vector table: write burst then read back (R2 R4 R5 R6 R7 R11)
        for (int v = 0; v < 6; v++) begin
            logic [7:0]  trk, sec, seed;
            logic [23:0] exp_a;
            {trk, sec, exp_a} = VEC[v];
            seed = 8'(v * 16 + 1);
            bus_wr(2'd0, trk);
            bus_wr(2'd1, sec);
            bus_wr(2'd3, 8'h00);
            wait_idle();
            check(m_cmd === 8'h02, "R4 write opcode", m_cmd, 8'h02);
            check(m_addr === exp_a, "R2 write start address", m_addr, exp_a);
            for (int k = 0; k < 4; k++) begin
                bus_wr(2'd2, 8'(seed + k));
                if (k == 0) begin
                    bus_rd(2'd3, d);
                    check(d[0] === 1'b1, "R7 busy during shift", d[0], 1);
                end
                wait_idle();
            end
            f0 = m_frames;
            bus_wr(2'd3, 8'h01);
            wait_idle();
            check(m_last_fbytes == 4, "R5 bytes in write frame", m_last_fbytes, 4);
            check(m_frames == f0 + 1, "R11 reopen frame count", m_frames, f0 + 1);
            check(m_cmd === 8'h03, "R4 read opcode", m_cmd, 8'h03);
            check(m_addr === exp_a, "R11 reopen at base", m_addr, exp_a);
            bus_rd(2'd3, d);
            check(d === 8'h06, "R7 status read burst idle", d, 8'h06);
            for (int k = 0; k < 4; k++) begin
                bus_rd(2'd2, d);
                check(d === 8'(seed + k), "R6 read back data", d, 8'(seed + k));
                wait_idle();
            end
        end

        // R6 and R8: unwritten area, write in read burst ignored
        bus_wr(2'd0, 8'h03);
        bus_wr(2'd1, 8'h09);
        bus_wr(2'd3, 8'h01);
        wait_idle();
        check(m_addr === 24'h018480, "R2 address 3/9", m_addr, 24'h018480);
        for (int k = 0; k < 3; k++) begin
            bus_wr(2'd2, 8'hEE);
            bus_rd(2'd3, d);
            check(d[0] === 1'b0, "R8 data write in read burst", d[0], 0);
            bus_rd(2'd2, d);
            check(d === pat(24'h018480 + 24'(k)), "R6 prefetch order", d, pat(24'h018480 + 24'(k)));
            wait_idle();
        end

        // R8: access while busy dropped; read in write burst dropped; R10 close
        bus_wr(2'd0, 8'h04);
        bus_wr(2'd1, 8'h02);
        bus_wr(2'd3, 8'h00);
        wait_idle();
        bus_wr(2'd2, 8'h11);
        bus_wr(2'd2, 8'hEE);
        wait_idle();
        bus_rd(2'd2, d);
        bus_rd(2'd3, d);
        check(d[0] === 1'b0, "R8 data read in write burst", d[0], 0);
        bus_wr(2'd2, 8'h22);
        wait_idle();
        bus_wr(2'd1, 8'h02);
        check(spi_cs_n === 1'b1, "R10 cs_n after sector write", int'(spi_cs_n), 1);
        check(m_last_fbytes == 2, "R8 busy write dropped", m_last_fbytes, 2);
        bus_rd(2'd3, d);
        check(d === 8'h00, "R10 status closed", d, 0);
        bus_wr(2'd3, 8'h01);
        wait_idle();
        bus_rd(2'd2, d);
        check(d === 8'h11, "R8 first byte kept", d, 8'h11);
        wait_idle();
        bus_rd(2'd2, d);
        check(d === 8'h22, "R8 second byte follows", d, 8'h22);
        wait_idle();

        // R9: burst cap and continuation
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd3, 8'h00);
        wait_idle();
        f0 = m_frames;
        for (int i = 0; i < 1030; i++) begin
            bus_wr(2'd2, 8'(i));
            wait_idle();
        end
        check(m_frames == f0 + 1, "R9 extra frame opened", m_frames, f0 + 1);
        check(m_addr === 24'h000400, "R9 continuation address", m_addr, 24'h000400);
        bus_wr(2'd0, 8'h00);
        check(m_max_fbytes == 1024, "R9 largest frame", m_max_fbytes, 1024);
        check(m_last_fbytes == 6, "R9 tail frame bytes", m_last_fbytes, 6);
        bus_wr(2'd1, 8'h08);
        bus_wr(2'd3, 8'h01);
        wait_idle();
        for (int k = 0; k < 6; k++) begin
            bus_rd(2'd2, d);
            check(d === 8'(k), "R9 data after cap", d, 8'(k));
            wait_idle();
        end

        summary();
    end
endmodule